// File: doc/BRIEF.md
# ECC Session Sequencer

This unit runs one error-correction session over a single sector of a flash data stream. Before the session starts, software writes the correction mode and the message length to a configuration word. It then writes the direction (encode while programming, decode while reading) and pulses a start bit in a control word. It also clears any earlier completion flags in a status word. While the session is open, the unit counts bytes on the data path. A byte is counted only when the external accumulation lock is low. When the session's byte budget is used up, the unit raises the completion flag that matches the direction. The parity and syndrome arithmetic is not part of this unit. The byte strobe stands in for it.

The byte budget depends on the direction. An encode ends once the message bytes have passed. A decode also has to consume the 13 stored parity bytes, so it ends after message + 13 bytes. When a decode ends, the unit stays busy for a fixed post-processing latency of `DEC_LATENCY` cycles.

The controller has three states:
- IDLE: no session is open.
- RUN: bytes are being counted.
- BUSY: decode post-processing is in progress.

The transitions are:
- start: any state to RUN, on the start bit.
- abort: any state to IDLE, on the abort bit.
- finish-encode: RUN to IDLE.
- finish-decode: RUN to BUSY.
- drain: BUSY to IDLE, when the latency expires.
- restart: BUSY to RUN, when a start bit arrives during BUSY.

Top module: `ecc_sess_ctrl`

## Requirements
- R1: After reset, `cfg_q`, `ctl_q` and `sts_q` all read 0, and no session is open.
- R2: A configuration write stores the mode from bits [1:0] and the message length minus one from bits [25:16]. `cfg_q` returns these two fields in the same positions, and every other bit reads 0.
- R3: Control bit 16 holds the direction (1 = encode, 0 = decode) and reads back at `ctl_q[16]`. The start bit (2) and the abort bit (0) act only as pulses and always read 0.
- R4: In encode direction, status bit 25 is set in the cycle after the (length)th counted byte, and not earlier. Busy stays low throughout.
- R5: In decode direction, status bit 24 is set in the cycle after the (length + 13)th counted byte, and not earlier.
- R6: A byte strobe is not counted while `lock_i` is high.
- R7: Bytes arriving while no session is open are ignored. This covers bytes before any start, and bytes after the budget has been reached and before the next start.
- R8: Status bit 31 (busy) rises together with the decode flag and stays high for exactly `DEC_LATENCY` cycles.
- R9: Writing 1 to status bit 25 or 24 clears that flag, and writing 0 leaves it unchanged. When a flag is set and cleared in the same cycle, the set wins.
- R10: A start pulse discards any partial count and opens a fresh session, including while busy. Busy drops at once.
- R11: An abort pulse closes the session and drops busy. Later bytes are ignored until the next start. When abort and start arrive together, abort wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control write data |
| sts_we | input | 1 | Status word write strobe (write 1 to clear) |
| sts_wdata | input | 32 | Status write data |
| lock_i | input | 1 | Accumulation lock; high stops counting |
| byte_vld | input | 1 | One data-path byte passes this cycle |
| cfg_q | output | 32 | Configuration readback |
| ctl_q | output | 32 | Control readback |
| sts_q | output | 32 | Status: bit 31 busy, bit 25 encode done, bit 24 decode done |

## Verification
Several properties assume things about the inputs:
- The configuration word and the direction bit do not change while a session is open.
- A configuration write never coincides with the byte that reaches the budget.
- `DEC_LATENCY` is at least 1.
- The flag-clear property is only checked outside RUN. This is because a completing byte may legally set the flag in the same cycle.

The stimulus follows these rules. Configuration writes and direction changes happen only between sessions, with the data strobe low. Control and status writes happen in their own cycles, except in the one deliberate test of set winning over clear. In that test, the status clear is placed on exactly the completing byte.

// File: rtl/ecc_sess_pkg.sv
`timescale 1ns/1ps
package ecc_sess_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_BUSY = 2'd2
    } sess_state_t;

    // Field positions decoded by software
    localparam int CFG_MODE_LSB  = 0;
    localparam int CFG_SIZE_LSB  = 16;
    localparam int CTL_ABORT_BIT = 0;
    localparam int CTL_START_BIT = 2;
    localparam int CTL_DIR_BIT   = 16;
    localparam int STS_DEC_BIT   = 24;
    localparam int STS_ENC_BIT   = 25;
    localparam int STS_BUSY_BIT  = 31;

endpackage

// File: rtl/ecc_sess_bytecnt.sv
`timescale 1ns/1ps
module ecc_sess_bytecnt #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= '0;
        else if (inc) count <= count + CNT_W'(1);
    end
endmodule

// File: rtl/ecc_sess_timer.sv
`timescale 1ns/1ps
module ecc_sess_timer #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic tick,
    output logic last
);
    localparam int TW = (LAT > 1) ? $clog2(LAT) : 1;

    logic [TW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     left_q <= '0;
        else if (load)                  left_q <= TW'(LAT - 1);
        else if (tick && left_q != '0)  left_q <= left_q - TW'(1);
    end

    assign last = (left_q == '0);
endmodule

// File: rtl/ecc_sess_regs.sv
`timescale 1ns/1ps
module ecc_sess_regs
    import ecc_sess_pkg::*;
#(
    parameter int MSG_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [31:0]      cfg_wdata,
    input  logic             ctl_we,
    input  logic [31:0]      ctl_wdata,
    input  logic             sts_we,
    input  logic [31:0]      sts_wdata,
    input  logic             set_enc,
    input  logic             set_dec,
    input  logic             busy,
    output logic [MSG_W-1:0] len_m1,
    output logic             dir_enc,
    output logic [31:0]      cfg_q,
    output logic [31:0]      ctl_q,
    output logic [31:0]      sts_q
);
    logic [1:0] mode_q;
    logic       enc_q;
    logic       dec_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= '0;
            len_m1  <= '0;
            dir_enc <= 1'b0;
        end else begin
            if (cfg_we) begin
                mode_q <= cfg_wdata[CFG_MODE_LSB +: 2];
                len_m1 <= cfg_wdata[CFG_SIZE_LSB +: MSG_W];
            end
            if (ctl_we)
                dir_enc <= ctl_wdata[CTL_DIR_BIT];
        end
    end

    // Set has priority over write-one-to-clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enc_q <= 1'b0;
            dec_q <= 1'b0;
        end else begin
            if (set_enc)                              enc_q <= 1'b1;
            else if (sts_we && sts_wdata[STS_ENC_BIT]) enc_q <= 1'b0;
            if (set_dec)                              dec_q <= 1'b1;
            else if (sts_we && sts_wdata[STS_DEC_BIT]) dec_q <= 1'b0;
        end
    end

    always_comb begin
        cfg_q = '0;
        cfg_q[CFG_MODE_LSB +: 2]     = mode_q;
        cfg_q[CFG_SIZE_LSB +: MSG_W] = len_m1;
        ctl_q = '0;
        ctl_q[CTL_DIR_BIT] = dir_enc;
        sts_q = '0;
        sts_q[STS_BUSY_BIT] = busy;
        sts_q[STS_ENC_BIT]  = enc_q;
        sts_q[STS_DEC_BIT]  = dec_q;
    end
endmodule

// File: rtl/ecc_sess_ctrl.sv
`timescale 1ns/1ps
module ecc_sess_ctrl
    import ecc_sess_pkg::*;
#(
    parameter int MSG_W       = 10,
    parameter int PAR_BYTES   = 13,
    parameter int DEC_LATENCY = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic        ctl_we,
    input  logic [31:0] ctl_wdata,
    input  logic        sts_we,
    input  logic [31:0] sts_wdata,
    input  logic        lock_i,
    input  logic        byte_vld,
    output logic [31:0] cfg_q,
    output logic [31:0] ctl_q,
    output logic [31:0] sts_q
);
    localparam int CNT_W = $clog2((1 << MSG_W) + PAR_BYTES + 1);

    sess_state_t      state_q, state_d;
    logic [MSG_W-1:0] len_m1;
    logic             dir_enc;
    logic [CNT_W-1:0] byte_cnt;
    logic [CNT_W-1:0] budget;
    logic             start_req, abort_req;
    logic             accept, hit, tmr_last;
    logic             set_enc, set_dec, busy;

    assign abort_req = ctl_we & ctl_wdata[CTL_ABORT_BIT];
    assign start_req = ctl_we & ctl_wdata[CTL_START_BIT] & ~abort_req;
    assign budget    = CNT_W'(len_m1) + CNT_W'(1)
                     + (dir_enc ? CNT_W'(0) : CNT_W'(PAR_BYTES));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (abort_req)      state_d = ST_IDLE;
        else if (start_req) state_d = ST_RUN;
        else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_RUN:  if (hit) state_d = dir_enc ? ST_IDLE : ST_BUSY;
                ST_BUSY: if (tmr_last) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs of the state machine
    always_comb begin
        accept  = 1'b0;
        busy    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  accept = byte_vld & ~lock_i & ~abort_req & ~start_req;
            ST_BUSY: busy   = 1'b1;
            default: ;
        endcase
        hit     = accept & ((byte_cnt + CNT_W'(1)) == budget);
        set_enc = hit & dir_enc;
        set_dec = hit & ~dir_enc;
    end

    ecc_sess_bytecnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_req | abort_req),
        .inc   (accept),
        .count (byte_cnt)
    );

    ecc_sess_timer #(.LAT(DEC_LATENCY)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (set_dec),
        .tick  (state_q == ST_BUSY),
        .last  (tmr_last)
    );

    ecc_sess_regs #(.MSG_W(MSG_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .sts_we    (sts_we),
        .sts_wdata (sts_wdata),
        .set_enc   (set_enc),
        .set_dec   (set_dec),
        .busy      (busy),
        .len_m1    (len_m1),
        .dir_enc   (dir_enc),
        .cfg_q     (cfg_q),
        .ctl_q     (ctl_q),
        .sts_q     (sts_q)
    );
endmodule

// File: rtl/ecc_sess_ctrl_chk.sv
`timescale 1ns/1ps
module ecc_sess_ctrl_chk
    import ecc_sess_pkg::*;
#(
    parameter int LAT   = 4,
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic [31:0]      ctl_wdata,
    input logic             sts_we,
    input logic [31:0]      sts_wdata,
    input logic             lock_i,
    input logic [31:0]      sts_q,
    input sess_state_t      state_q,
    input logic [CNT_W-1:0] count
);
    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        busy_run <= 0;
        else if (sts_q[31]) busy_run <= busy_run + 1;
        else               busy_run <= 0;
    end

    // R8
    busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[31]) |-> sts_q[24]);

    // R8
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_q[31] |-> (busy_run < LAT));

    // R4
    enc_nobusy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[25]) |-> !sts_q[31]);

    // R6
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && !ctl_we) |=> $stable(count));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !ctl_we) |=> $stable(count));

    // R9
    w1c_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && sts_wdata[25] && state_q != ST_RUN) |=> !sts_q[25]);

    // R9
    w1c_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_we && sts_wdata[24] && state_q != ST_RUN) |=> !sts_q[24]);

    // R10
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[2] && !ctl_wdata[0])
        |=> (count == '0 && state_q == ST_RUN && !sts_q[31]));

    // R11
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[0]) |=> (state_q == ST_IDLE && !sts_q[31]));
endmodule

bind ecc_sess_ctrl ecc_sess_ctrl_chk #(.LAT(DEC_LATENCY), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .sts_we    (sts_we),
    .sts_wdata (sts_wdata),
    .lock_i    (lock_i),
    .sts_q     (sts_q),
    .state_q   (state_q),
    .count     (byte_cnt)
);

// File: tb/ecc_sess_ctrl_test.sv
`timescale 1ns/1ps
module ecc_sess_ctrl_test;
    localparam int LAT = 4;
    localparam int PAR = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        sts_we = 1'b0;
    logic [31:0] sts_wdata = '0;
    logic        lock_i = 1'b0;
    logic        byte_vld = 1'b0;
    logic [31:0] cfg_q, ctl_q, sts_q;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    ecc_sess_ctrl #(.MSG_W(10), .PAR_BYTES(PAR), .DEC_LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .sts_we(sts_we), .sts_wdata(sts_wdata),
        .lock_i(lock_i), .byte_vld(byte_vld),
        .cfg_q(cfg_q), .ctl_q(ctl_q), .sts_q(sts_q)
    );

    // Behavioural reference model
    int m_mode, m_len_m1, m_dir, m_enc, m_dec, m_open, m_cnt, m_busy_left, m_tgt;
    bit m_se, m_sd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_len_m1 = 0; m_dir = 0; m_enc = 0; m_dec = 0;
            m_open = 0; m_cnt = 0; m_busy_left = 0;
        end else begin
            m_se = 0; m_sd = 0;
            if (m_busy_left > 0) m_busy_left--;
            m_tgt = m_len_m1 + 1 + (m_dir != 0 ? 0 : PAR);
            if (ctl_we && ctl_wdata[0]) begin
                m_open = 0; m_busy_left = 0;
            end else if (ctl_we && ctl_wdata[2]) begin
                m_open = 1; m_cnt = 0; m_busy_left = 0;
            end else if (m_open != 0 && byte_vld && !lock_i) begin
                m_cnt++;
                if (m_cnt == m_tgt) begin
                    m_open = 0;
                    if (m_dir != 0) m_se = 1;
                    else begin m_sd = 1; m_busy_left = LAT; end
                end
            end
            if (ctl_we) m_dir = ctl_wdata[16];
            if (cfg_we) begin
                m_mode = cfg_wdata[1:0];
                m_len_m1 = cfg_wdata[25:16];
            end
            if (sts_we && sts_wdata[25]) m_enc = 0;
            if (sts_we && sts_wdata[24]) m_dec = 0;
            if (m_se) m_enc = 1;
            if (m_sd) m_dec = 1;
        end
    end

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic compare();
        logic [31:0] e_cfg, e_ctl, e_sts;
        e_cfg = {6'b0, 10'(m_len_m1), 14'b0, 2'(m_mode)};
        e_ctl = {15'b0, 1'(m_dir), 16'b0};
        e_sts = {(m_busy_left > 0), 5'b0, 1'(m_enc), 1'(m_dec), 24'b0};
        chk({cur_req, " cfg"}, cfg_q, e_cfg);
        chk({cur_req, " ctl"}, ctl_q, e_ctl);
        chk({cur_req, " sts"}, sts_q, e_sts);
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic wr_cfg(logic [31:0] d);
        cfg_we = 1; cfg_wdata = d; tick(); cfg_we = 0;
    endtask

    task automatic wr_ctl(logic [31:0] d);
        ctl_we = 1; ctl_wdata = d; tick(); ctl_we = 0;
    endtask

    task automatic wr_sts(logic [31:0] d);
        sts_we = 1; sts_wdata = d; tick(); sts_we = 0;
    endtask

    task automatic push(int n, bit lk);
        for (int i = 0; i < n; i++) begin
            byte_vld = 1; lock_i = lk; tick();
        end
        byte_vld = 0; lock_i = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1", cfg_q, 32'h0); chk("R1", ctl_q, 32'h0); chk("R1", sts_q, 32'h0);

        // R7 bytes before any start are ignored
        cur_req = "R7";
        push(4, 0);
        chk("R7", sts_q, 32'h0);

        // R2 field placement, all-ones write
        cur_req = "R2";
        wr_cfg(32'hFFFF_FFFF);
        chk("R2", cfg_q, 32'h03FF_0003);
        wr_cfg(32'h01FF_0003);
        chk("R2", cfg_q, 32'h01FF_0003);

        // R3 direction readback, pulses read 0; R4 encode of 512
        cur_req = "R4";
        wr_ctl(32'h0001_0005 & 32'hFFFF_FFFE | 32'h0001_0004);
        chk("R3", ctl_q, 32'h0001_0000);
        push(511, 0);
        chk("R4", sts_q, 32'h0);
        push(1, 0);
        chk("R4", sts_q, 32'h0200_0000);
        repeat (5) tick();
        chk("R4", sts_q, 32'h0200_0000);

        // R7 bytes after the budget are ignored
        cur_req = "R7";
        wr_sts(32'h0200_0000);
        push(5, 0);
        chk("R7", sts_q, 32'h0);

        // R5/R6 decode of 512+13 with locked bytes mixed in; R8 busy window
        cur_req = "R5";
        wr_ctl(32'h0000_0004);
        push(300, 0);
        push(10, 1);
        push(224, 0);
        chk("R5", sts_q, 32'h0);
        push(1, 0);
        chk("R5", sts_q, 32'h8100_0000);
        cur_req = "R8";
        for (int i = 0; i < LAT - 1; i++) begin
            tick();
            chk("R8", sts_q, 32'h8100_0000);
        end
        tick();
        chk("R8", sts_q, 32'h0100_0000);

        // R6 lock on a short encode
        cur_req = "R6";
        wr_cfg(32'h0007_0003);
        wr_ctl(32'h0001_0004);
        push(7, 0);
        push(3, 1);
        chk("R6", sts_q, 32'h0100_0000);
        push(1, 0);
        chk("R6", sts_q, 32'h0300_0000);

        // R9 write-one-to-clear selectivity and set priority
        cur_req = "R9";
        wr_sts(32'h0100_0000);
        chk("R9", sts_q, 32'h0200_0000);
        wr_sts(32'h0000_0000);
        chk("R9", sts_q, 32'h0200_0000);
        wr_sts(32'h0200_0000);
        chk("R9", sts_q, 32'h0);
        wr_ctl(32'h0001_0004);
        push(7, 0);
        byte_vld = 1; sts_we = 1; sts_wdata = 32'h0200_0000;
        tick();
        byte_vld = 0; sts_we = 0;
        chk("R9", sts_q, 32'h0200_0000);

        // R10 restart discards partial count
        cur_req = "R10";
        wr_sts(32'h0300_0000);
        wr_ctl(32'h0001_0004);
        push(5, 0);
        wr_ctl(32'h0001_0004);
        push(7, 0);
        chk("R10", sts_q, 32'h0);
        push(1, 0);
        chk("R10", sts_q, 32'h0200_0000);

        // R10 restart during busy drops busy
        wr_sts(32'h0200_0000);
        wr_ctl(32'h0000_0004);
        push(8 + PAR, 0);
        chk("R10", sts_q, 32'h8100_0000);
        wr_ctl(32'h0000_0004);
        chk("R10", sts_q, 32'h0100_0000);

        // R11 abort drops busy, abort mid-session, abort beats start
        cur_req = "R11";
        wr_sts(32'h0100_0000);
        wr_ctl(32'h0000_0004);
        push(8 + PAR, 0);
        wr_ctl(32'h0000_0001);
        chk("R11", sts_q, 32'h0100_0000);
        wr_sts(32'h0100_0000);
        wr_ctl(32'h0000_0004);
        push(10, 0);
        wr_ctl(32'h0000_0001);
        push(20, 0);
        chk("R11", sts_q, 32'h0);
        wr_ctl(32'h0000_0005);
        push(25, 0);
        chk("R11", sts_q, 32'h0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule